// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers eight interrupt request lines, remembers which of them have fired, and raises one interrupt output toward a processor whenever an enabled request outranks everything the processor is already servicing. When the processor answers with a one-cycle acknowledge pulse, the block hands back an 8-bit vector formed from a fixed base parameter plus the number of the winning line. The winner moves from the pending set into the in-service set.

Software reaches the block over a small register bus with a single address bit, read and write strobes, and 8-bit data. The upper address holds a read/write mask byte. The lower address takes commands on writes and returns status on reads. One command retires the most urgent in-service entry. Two others choose whether status reads show the pending set or the in-service set. Line 0 has the top priority and line 7 the lowest. Handlers may nest: a more urgent line can preempt a handler that is already running.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the mask byte reads 0xFF, the pending and in-service sets are empty, status reads at address 0 return the pending set, and the interrupt output is low.
- R2: A low-to-high change on a request line sets its pending bit once. A line that stays high does not set the bit again after it has been acknowledged.
- R3: A mask bit of 1 keeps its line from raising the interrupt output, but the pending bit is still recorded. Clearing the mask bit to 0 lets the line compete again.
- R4: A write at address 1 loads the mask byte, and a read at address 1 returns it.
- R5: When several lines are eligible, the lowest-numbered line wins the acknowledge.
- R6: During an acknowledge cycle with an eligible winner, the block drives vector-valid high and the vector equal to VEC_BASE plus the line number. The winner's pending bit clears and its in-service bit sets at the next clock edge.
- R7: The interrupt output is high only while an unmasked pending line has a lower number than every in-service line. A more urgent line can therefore nest over a less urgent handler.
- R8: Writing 0x20 at address 0 clears only the lowest-numbered set bit of the in-service set.
- R9: Writing 0x0A at address 0 makes status reads return the pending set, and writing 0x0B makes them return the in-service set. Any other value written at address 0 changes nothing.
- R10: An acknowledge while no line is eligible leaves vector-valid low and changes neither set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 8 | Request lines, rising edge captured |
| bus_addr | input | 1 | Register select: 0 command/status, 1 mask |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, zero when not reading |
| int_out | output | 1 | Interrupt request to the processor |
| ack | input | 1 | One-cycle acknowledge from the processor |
| vec_out | output | 8 | Vector, valid during the acknowledge cycle |
| vec_valid | output | 1 | Vector qualifier |

## Verification
A stray or missing in-service bit changes which requests may nest, so the interrupt output goes wrong in the very next cycle. The next status read in in-service mode also shows the bad byte. A pending bit that fails to clear on acknowledge shows up as a second identical vector on the following acknowledge. An end-of-interrupt that clears the wrong bit lets a blocked, less urgent line raise the output one cycle after the write. The stimulus is therefore arranged so that every grant and every retire is followed immediately by a check of the output level, the vector, or a status read.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int NLINE = 8;
    localparam int DW    = 8;
    localparam int IW    = $clog2(NLINE);

    localparam logic [DW-1:0] CODE_RETIRE  = 8'h20;
    localparam logic [DW-1:0] CODE_SEE_REQ = 8'h0A;
    localparam logic [DW-1:0] CODE_SEE_SVC = 8'h0B;

    typedef enum logic [2:0] {
        OPC_NONE,
        OPC_RETIRE,
        OPC_SEE_REQ,
        OPC_SEE_SVC,
        OPC_MASK
    } irqc_opc_e;

    typedef struct packed {
        logic [NLINE-1:0] prev;
        logic [NLINE-1:0] irr;
        logic [NLINE-1:0] isr;
        logic [NLINE-1:0] imr;
        logic             sel_isr;
    } irqc_state_t;
endpackage

// File: rtl/irqc_lowbit.sv
module irqc_lowbit #(
    parameter int W  = 8,
    parameter int XW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic [W-1:0]  onehot,
    output logic [XW-1:0] idx,
    output logic          found
);
    always_comb begin
        onehot = '0;
        idx    = '0;
        found  = 1'b0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) begin
                onehot    = '0;
                onehot[i] = 1'b1;
                idx       = XW'(i);
                found     = 1'b1;
            end
        end
    end
endmodule

// File: rtl/irqc_cmd_dec.sv
module irqc_cmd_dec
    import irqc_pkg::*;
(
    input  logic          wr,
    input  logic          addr,
    input  logic [DW-1:0] data,
    output irqc_opc_e     opc
);
    always_comb begin
        opc = OPC_NONE;
        if (wr) begin
            if (addr) begin
                opc = OPC_MASK;
            end else begin
                unique case (data)
                    CODE_RETIRE:  opc = OPC_RETIRE;
                    CODE_SEE_REQ: opc = OPC_SEE_REQ;
                    CODE_SEE_SVC: opc = OPC_SEE_SVC;
                    default:      opc = OPC_NONE;
                endcase
            end
        end
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import irqc_pkg::*;
#(
    parameter logic [7:0] VEC_BASE = 8'h08
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NLINE-1:0] irq_in,
    input  logic             bus_addr,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata,
    output logic             int_out,
    input  logic             ack,
    output logic [DW-1:0]    vec_out,
    output logic             vec_valid
);
    irqc_state_t st_d, st_q;
    irqc_opc_e   opc;

    logic [NLINE-1:0] rise, pend, allowed, elig;
    logic [NLINE-1:0] win_oh, svc_oh;
    logic [IW-1:0]    win_idx, svc_idx;
    logic             win_found, svc_found, grant;

    irqc_cmd_dec u_dec (
        .wr   (bus_wr),
        .addr (bus_addr),
        .data (bus_wdata),
        .opc  (opc)
    );

    irqc_lowbit #(.W(NLINE)) u_svc (
        .vec    (st_q.isr),
        .onehot (svc_oh),
        .idx    (svc_idx),
        .found  (svc_found)
    );

    always_comb begin
        for (int i = 0; i < NLINE; i++) begin
            allowed[i] = !svc_found || (IW'(i) < svc_idx);
        end
        pend = st_q.irr & ~st_q.imr;
        elig = pend & allowed;
        rise = irq_in & ~st_q.prev;
    end

    irqc_lowbit #(.W(NLINE)) u_win (
        .vec    (elig),
        .onehot (win_oh),
        .idx    (win_idx),
        .found  (win_found)
    );

    always_comb begin
        st_d      = st_q;
        grant     = ack && win_found;
        st_d.prev = irq_in;
        st_d.irr  = (st_q.irr & ~(grant ? win_oh : '0)) | rise;
        st_d.isr  = (st_q.isr & ~((opc == OPC_RETIRE) ? svc_oh : '0))
                  | (grant ? win_oh : '0);
        if (opc == OPC_MASK)    st_d.imr     = bus_wdata;
        if (opc == OPC_SEE_REQ) st_d.sel_isr = 1'b0;
        if (opc == OPC_SEE_SVC) st_d.sel_isr = 1'b1;

        int_out   = win_found;
        vec_valid = grant;
        vec_out   = grant ? (VEC_BASE + DW'(win_idx)) : '0;
        if (!bus_rd)       bus_rdata = '0;
        else if (bus_addr) bus_rdata = st_q.imr;
        else               bus_rdata = st_q.sel_isr ? st_q.isr : st_q.irr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.prev    <= '0;
            st_q.irr     <= '0;
            st_q.isr     <= '0;
            st_q.imr     <= '1;
            st_q.sel_isr <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk
    import irqc_pkg::*;
#(
    parameter logic [7:0] VEC_BASE = 8'h08
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ack,
    input logic             vec_valid,
    input logic [DW-1:0]    vec_out,
    input logic             int_out,
    input logic             bus_wr,
    input logic             bus_addr,
    input logic [DW-1:0]    bus_wdata,
    input logic [NLINE-1:0] imr_q,
    input logic [NLINE-1:0] isr_q
);
    logic [DW-1:0]    vec_off;
    logic [IW-1:0]    vec_idx;
    logic [NLINE-1:0] upto_mask;
    logic             retire_wr;

    always_comb begin
        vec_off   = vec_out - VEC_BASE;
        vec_idx   = vec_off[IW-1:0];
        retire_wr = bus_wr && !bus_addr && (bus_wdata == 8'h20);
        for (int i = 0; i < NLINE; i++) begin
            upto_mask[i] = (IW'(i) <= vec_idx);
        end
    end

    assert_vld_needs_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> ack);
    assert_vec_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> (vec_out >= VEC_BASE && vec_off < DW'(NLINE)));
    assert_grant_enters_svc_R6: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |=> isr_q[$past(vec_idx)]);
    assert_nest_only_higher_R7: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> ((isr_q & upto_mask) == '0));
    assert_mask_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr) |=> (imr_q == $past(bus_wdata)));
    assert_all_masked_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (imr_q == '1) |-> !int_out);
    assert_retire_one_bit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (retire_wr && (isr_q != '0) && !vec_valid)
        |=> ($countones(isr_q) == $countones($past(isr_q)) - 1));
endmodule

bind prio_irq_ctrl irqc_chk #(.VEC_BASE(VEC_BASE)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ack       (ack),
    .vec_valid (vec_valid),
    .vec_out   (vec_out),
    .int_out   (int_out),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .imr_q     (st_q.imr),
    .isr_q     (st_q.isr)
);

// File: tb/tb_prio_irq_ctrl.sv
module tb_prio_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq_in = '0;
    logic       bus_addr = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       int_out;
    logic       ack = 1'b0;
    logic [7:0] vec_out;
    logic       vec_valid;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    prio_irq_ctrl #(.VEC_BASE(8'h08)) dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .int_out(int_out), .ack(ack),
        .vec_out(vec_out), .vec_valid(vec_valid)
    );

    typedef struct packed {
        logic [2:0] op;
        logic [7:0] arg;
        logic [7:0] exp;
        logic [3:0] req;
    } step_t;

    localparam logic [2:0] OP_WR0 = 3'd0, OP_WR1 = 3'd1, OP_RD0 = 3'd2,
                           OP_RD1 = 3'd3, OP_IRQ = 3'd4, OP_ACK = 3'd5,
                           OP_INT = 3'd6;
    localparam int NT = 48;
    // ACK rows: exp 0x00 means no vector expected (R10); base 0x08 never yields 0.
    localparam step_t TBL [NT] = '{
        '{OP_RD1, 8'h00, 8'hFF, 4'd1},  // R1 mask all set
        '{OP_RD0, 8'h00, 8'h00, 4'd1},  // R1 pending empty
        '{OP_INT, 8'h00, 8'h00, 4'd1},  // R1 output low
        '{OP_WR1, 8'h00, 8'h00, 4'd4},  // R4 unmask all
        '{OP_RD1, 8'h00, 8'h00, 4'd4},  // R4 readback
        '{OP_IRQ, 8'h20, 8'h00, 4'd2},  // R2 line 5
        '{OP_RD0, 8'h00, 8'h20, 4'd2},
        '{OP_INT, 8'h00, 8'h01, 4'd7},  // R7
        '{OP_IRQ, 8'h08, 8'h00, 4'd2},  // line 3
        '{OP_RD0, 8'h00, 8'h28, 4'd2},
        '{OP_ACK, 8'h00, 8'h0B, 4'd5},  // R5 line 3 beats 5
        '{OP_RD0, 8'h00, 8'h20, 4'd6},  // R6 pending cleared
        '{OP_WR0, 8'h0B, 8'h00, 4'd9},  // R9 select service
        '{OP_RD0, 8'h00, 8'h08, 4'd9},
        '{OP_INT, 8'h00, 8'h00, 4'd7},  // R7 line 5 blocked
        '{OP_IRQ, 8'h02, 8'h00, 4'd7},  // line 1
        '{OP_INT, 8'h00, 8'h01, 4'd7},
        '{OP_ACK, 8'h00, 8'h09, 4'd7},  // nested
        '{OP_RD0, 8'h00, 8'h0A, 4'd7},
        '{OP_ACK, 8'h00, 8'h00, 4'd10}, // R10 nothing eligible
        '{OP_RD0, 8'h00, 8'h0A, 4'd10},
        '{OP_WR0, 8'h20, 8'h00, 4'd8},  // R8 retire
        '{OP_RD0, 8'h00, 8'h08, 4'd8},
        '{OP_INT, 8'h00, 8'h00, 4'd8},
        '{OP_WR0, 8'h55, 8'h00, 4'd9},  // R9 ignored code
        '{OP_RD0, 8'h00, 8'h08, 4'd9},
        '{OP_WR0, 8'h20, 8'h00, 4'd8},
        '{OP_RD0, 8'h00, 8'h00, 4'd8},
        '{OP_INT, 8'h00, 8'h01, 4'd7},
        '{OP_ACK, 8'h00, 8'h0D, 4'd6},
        '{OP_WR0, 8'h20, 8'h00, 4'd8},
        '{OP_WR1, 8'h80, 8'h00, 4'd3},  // R3 mask line 7
        '{OP_IRQ, 8'h80, 8'h00, 4'd3},
        '{OP_INT, 8'h00, 8'h00, 4'd3},
        '{OP_WR0, 8'h0A, 8'h00, 4'd9},
        '{OP_RD0, 8'h00, 8'h80, 4'd3},  // still recorded
        '{OP_WR1, 8'h00, 8'h00, 4'd3},
        '{OP_INT, 8'h00, 8'h01, 4'd3},
        '{OP_ACK, 8'h00, 8'h0F, 4'd6},
        '{OP_WR0, 8'h20, 8'h00, 4'd8},
        '{OP_IRQ, 8'h81, 8'h00, 4'd5},  // lines 0 and 7 together
        '{OP_ACK, 8'h00, 8'h08, 4'd5},
        '{OP_INT, 8'h00, 8'h00, 4'd7},
        '{OP_WR0, 8'h20, 8'h00, 4'd8},
        '{OP_INT, 8'h00, 8'h01, 4'd5},
        '{OP_ACK, 8'h00, 8'h0F, 4'd5},
        '{OP_WR0, 8'h20, 8'h00, 4'd8},
        '{OP_RD0, 8'h00, 8'h00, 4'd6}
    };

    task automatic judge(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic a, input logic [7:0] exp, input string tag);
        bus_addr = a; bus_rd = 1'b1;
        #1;
        judge(tag, bus_rdata, exp);
        bus_rd = 1'b0;
    endtask

    task automatic pulse(input logic [7:0] v);
        irq_in = v;
        @(negedge clk);
        irq_in = '0;
        @(negedge clk);
    endtask

    task automatic ack_chk(input logic [7:0] exp, input string tag);
        ack = 1'b1;
        #1;
        if (exp == 8'h00) judge(tag, {7'b0, vec_valid}, 8'h00);
        else judge(tag, vec_valid ? vec_out : 8'hEE, exp);
        @(negedge clk);
        ack = 1'b0;
    endtask

    task automatic int_chk(input logic exp, input string tag);
        #1;
        judge(tag, {7'b0, int_out}, {7'b0, exp});
    endtask

    task automatic finish_run;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        for (int k = 0; k < NT; k++) begin
            string tag;
            tag = $sformatf("R%0d step %0d", TBL[k].req, k);
            case (TBL[k].op)
                OP_WR0: wr(1'b0, TBL[k].arg);
                OP_WR1: wr(1'b1, TBL[k].arg);
                OP_RD0: rd_chk(1'b0, TBL[k].exp, tag);
                OP_RD1: rd_chk(1'b1, TBL[k].exp, tag);
                OP_IRQ: pulse(TBL[k].arg);
                OP_ACK: ack_chk(TBL[k].exp, tag);
                OP_INT: int_chk(TBL[k].exp[0], tag);
                default: ;
            endcase
        end

        // R2: a line held high is captured once only
        irq_in = 8'h40;
        repeat (2) @(negedge clk);
        ack_chk(8'h0E, "R2 held line vector");
        repeat (3) @(negedge clk);
        rd_chk(1'b0, 8'h00, "R2 held line not re-captured");
        int_chk(1'b0, "R2 held line no output");
        wr(1'b0, 8'h20);
        irq_in = '0;
        @(negedge clk);

        // R1: reset in the middle of activity
        wr(1'b1, 8'h3C);
        pulse(8'h01);
        ack_chk(8'h08, "R1 pre-reset grant");
        wr(1'b0, 8'h0B);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd_chk(1'b1, 8'hFF, "R1 mask after reset");
        rd_chk(1'b0, 8'h00, "R1 status after reset");
        int_chk(1'b0, "R1 output after reset");
        wr(1'b1, 8'h00);
        pulse(8'h04);
        rd_chk(1'b0, 8'h04, "R1 status selects pending after reset");

        finish_run();
    end
endmodule